// File: doc/BRIEF.md
# Controlled Slip Frame Buffer

This block is an elastic store placed between a writer paced by recovered line timing and a reader paced by local timing on a frame-structured TDM link. Bytes enter and leave in frame order. Both sides share one clock here, and each side has its own enable. When the two sides run at slightly different rates, the number of buffered bytes drifts. The buffer corrects this drift only at read-side frame boundaries, and it does so in whole frames. When the writer has pulled too far ahead, the buffer drops the next frame outright. When the reader has caught up with the writer, it plays the frame it has just delivered a second time. Because every correction moves exactly one frame, the start-of-frame marker on the output stays correct.

Each correction produces a one-cycle event pulse with a direction bit. Deletions and repetitions are tallied in two separate saturating counters, so that slip rates can be monitored over long periods. A synchronous clear input zeroes both counters.

After reset the buffer holds one frame of zero bytes, so the reader starts half a buffer behind the writer. The writer's first byte after reset begins a frame.

Top module: `slip_frame_buffer`

## Requirements
- R1: After reset, rd_valid, slip_pulse and both counters are 0, and occupancy is 32 bytes (one frame of zeros). The first 32 bytes read after reset are 0x00, and the bytes written next follow them.
- R2: When the two sides transfer at equal rates, the output is the written byte stream in write order, with no slips.
- R3: A read accepted at a clock edge places its byte on rd_data with rd_valid=1 for the following cycle. rd_sof=1 marks the first byte of each 32-byte frame; otherwise rd_valid=0 and rd_sof=0.
- R4: A slip is decided only on the read of the 32nd byte of a frame. The decision uses the occupancy after that cycle's read and write. Above 48 the buffer deletes a frame, below 16 it repeats one, and anywhere from 16 to 48 it does neither. Occupancy never exceeds the 64-byte capacity.
- R5: On deletion, the 32 oldest bytes still stored (the next frame) are discarded, and reading continues with the frame after them.
- R6: On repetition, the 32 bytes of the frame just completed are output again, in order, before newer data.
- R7: Each slip raises slip_pulse for exactly the one cycle after the boundary read, with slip_dir=1 for a deletion and 0 for a repetition.
- R8: del_count and rep_count each add one per deletion or repetition respectively, and saturate at all ones (16 bits by default).
- R9: cnt_clear=1 at a clock edge zeroes both counters, overriding a slip counted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one byte this cycle |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read one byte this cycle |
| rd_data | output | 8 | Byte read in the previous cycle |
| rd_valid | output | 1 | rd_data is new this cycle |
| rd_sof | output | 1 | rd_data is the first byte of a frame |
| slip_pulse | output | 1 | One-cycle slip event |
| slip_dir | output | 1 | 1 = frame deleted, 0 = frame repeated |
| del_count | output | 16 | Saturating count of deletions |
| rep_count | output | 16 | Saturating count of repetitions |
| cnt_clear | input | 1 | Zero both counters |

## Verification
A wrong read pointer or a wrong occupancy count shows at the ports as a byte that differs from the written stream on the next valid read. At a slip it shows as a frame that is shifted, missing or repeated too many times, and rd_sof moves off the first byte of the frame within the same frame. A threshold compared against the wrong value shows as a slip_pulse at the wrong boundary, or as one that is missing, within one frame of the drift. A counter fault shows in the same cycle as the slip pulse. The reference model is compared against every byte, every marker and every counter value on every clock, so any such divergence is reported at the cycle where it first appears.

// File: rtl/slip_frame_buffer.sv
module slip_frame_buffer #(
  parameter int FRAME  = 32,
  parameter int FRAMES = 2,
  parameter int DW     = 8,
  parameter int CNT_W  = 16,
  parameter int HI_LIM = 48,
  parameter int LO_LIM = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             rd_sof,
  output logic             slip_pulse,
  output logic             slip_dir,
  output logic [CNT_W-1:0] del_count,
  output logic [CNT_W-1:0] rep_count,
  input  logic             cnt_clear
);
  localparam int DEPTH = FRAME * FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(FRAME);
  localparam int OW    = AW + 2;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [OW-1:0] fill, fill_nx;
  logic          at_end, do_del, do_rep;

  assign at_end  = rd_en && (rp[FW-1:0] == FW'(FRAME - 1));
  assign fill_nx = fill + OW'(wr_en) - OW'(rd_en);
  assign do_del  = at_end && (fill_nx > OW'(HI_LIM));
  assign do_rep  = at_end && (fill_nx < OW'(LO_LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wp] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= AW'(FRAME);
      fill <= OW'(FRAME);
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1 + (do_del ? AW'(FRAME) : '0) - (do_rep ? AW'(FRAME) : '0);
      fill <= fill_nx - (do_del ? OW'(FRAME) : '0) + (do_rep ? OW'(FRAME) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_sof   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_sof   <= rd_en && (rp[FW-1:0] == '0);
      if (rd_en) rd_data <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_pulse <= 1'b0;
      slip_dir   <= 1'b0;
      del_count  <= '0;
      rep_count  <= '0;
    end else begin
      slip_pulse <= do_del || do_rep;
      if (do_del || do_rep) slip_dir <= do_del;
      if (cnt_clear) begin
        del_count <= '0;
        rep_count <= '0;
      end else begin
        if (do_del && del_count != CMAX) del_count <= del_count + 1'b1;
        if (do_rep && rep_count != CMAX) rep_count <= rep_count + 1'b1;
      end
    end
  end

  assert_fill_cap_R4: assert property (@(posedge clk) disable iff (rst)
    fill <= OW'(DEPTH));

  assert_pulse_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |-> rd_valid && !rd_sof);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> !slip_pulse);

  assert_sof_realign_R5: assert property (@(posedge clk) disable iff (rst)
    slip_pulse && rd_en |=> rd_sof);

  assert_del_step_R8: assert property (@(posedge clk) disable iff (rst)
    slip_pulse && slip_dir && !$past(cnt_clear) |->
      del_count == (($past(del_count) == CMAX) ? CMAX : $past(del_count) + 1'b1));

  assert_rep_step_R8: assert property (@(posedge clk) disable iff (rst)
    slip_pulse && !slip_dir && !$past(cnt_clear) |->
      rep_count == (($past(rep_count) == CMAX) ? CMAX : $past(rep_count) + 1'b1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !slip_pulse && !$past(cnt_clear) |-> $stable(del_count) && $stable(rep_count));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_clear) |-> del_count == '0 && rep_count == '0);
endmodule

// File: tb/sim_slip_frame_buffer.sv
module sim_slip_frame_buffer;
  localparam int FRAME = 32;
  localparam int SATMAX = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, cnt_clear = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, rd_data1;
  logic rd_valid, rd_sof, slip_pulse, slip_dir;
  logic rd_valid1, rd_sof1, slip_pulse1, slip_dir1;
  logic [15:0] del_count, rep_count;
  logic [2:0] del_count1, rep_count1;

  int checks = 0, errors = 0;
  int q[$];
  int lastf[FRAME];
  int mcnt = 0, md = 0, mr = 0;
  bit e_valid = 0, e_sof = 0, e_pulse = 0, e_dir = 0;
  int e_data = 0;
  string ptag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  slip_frame_buffer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_sof(rd_sof), .slip_pulse(slip_pulse),
    .slip_dir(slip_dir), .del_count(del_count), .rep_count(rep_count), .cnt_clear(cnt_clear));

  slip_frame_buffer #(.CNT_W(3)) u1 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data1), .rd_valid(rd_valid1), .rd_sof(rd_sof1),
    .slip_pulse(slip_pulse1), .slip_dir(slip_dir1), .del_count(del_count1),
    .rep_count(rep_count1), .cnt_clear(cnt_clear));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(rd_valid == e_valid, "R3 rd_valid", rd_valid, e_valid);
    if (e_valid) begin
      chk(rd_data == 8'(e_data), {ptag, " rd_data"}, rd_data, e_data);
      chk(rd_sof == e_sof, "R3 rd_sof", rd_sof, e_sof);
    end
    chk(slip_pulse == e_pulse, "R7 slip_pulse", slip_pulse, e_pulse);
    if (e_pulse) chk(slip_dir == e_dir, "R7 slip_dir", slip_dir, e_dir);
    chk(del_count == 16'(md), "R8 del_count", del_count, md);
    chk(rep_count == 16'(mr), "R8 rep_count", rep_count, mr);
    chk(del_count1 == 3'(md > SATMAX ? SATMAX : md), "R8 sat del", del_count1, md > SATMAX ? SATMAX : md);
    chk(rep_count1 == 3'(mr > SATMAX ? SATMAX : mr), "R8 sat rep", rep_count1, mr > SATMAX ? SATMAX : mr);
  endtask

  task automatic step(input bit we, input bit re, input bit clr);
    int b, n;
    @(negedge clk);
    compare();
    wr_en = we; rd_en = re; cnt_clear = clr;
    wr_data = 8'($urandom);
    e_pulse = 0; e_valid = re;
    if (re) begin
      b = q.pop_front();
      e_data = b; e_sof = (mcnt == 0);
      lastf[mcnt] = b;
      mcnt++;
    end
    if (we) q.push_back(int'(wr_data));
    if (re && mcnt == FRAME) begin
      mcnt = 0;
      n = q.size();
      if (n > 48) begin
        for (int i = 0; i < FRAME; i++) void'(q.pop_front());
        e_pulse = 1; e_dir = 1; md++;
      end else if (n < 16) begin
        for (int i = FRAME - 1; i >= 0; i--) q.push_front(lastf[i]);
        e_pulse = 1; e_dir = 0; mr++;
      end
    end
    if (clr) begin md = 0; mr = 0; end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    chk(rd_valid == 0 && slip_pulse == 0 && del_count == 0, "R1 reset state", rd_valid, 0);
    rst = 1'b0;
    for (int i = 0; i < FRAME; i++) q.push_back(0);
    for (int i = 0; i < 40; i++) step(1, 1, 0);
    ptag = "R2";
    for (int i = 0; i < 400; i++) begin
      bit g = 1'($urandom);
      step(g, g, 0);
    end
    chk(md == 0 && mr == 0 && del_count == 0 && rep_count == 0, "R4 no slip at equal rate", del_count + rep_count, 0);
    ptag = "R5";
    for (int i = 0; i < 1500; i++) step(1, (i % 4) != 3, 0);
    chk(del_count > 0 && rep_count == 0, "R5 deletions seen", del_count, md);
    ptag = "R6";
    for (int i = 0; i < 1500; i++) step((i % 4) != 3, 1, 0);
    chk(rep_count > 0, "R6 repetitions seen", rep_count, mr);
    step(1, 1, 1);
    step(1, 1, 0);
    chk(del_count == 0 && rep_count == 0, "R9 clear", del_count + rep_count, 0);
    for (int i = 0; i < 400; i++) step(0, 1, (mcnt == FRAME - 1) && (i > 100) && (i < 140));
    chk(rep_count1 == 3'(SATMAX), "R8 saturation", rep_count1, SATMAX);
    for (int i = 0; i < 200; i++) step(1, 1, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule